// File: doc/BRIEF.md
# Supervisory Reset Timeout Generator

This block produces the active-low system reset of a supply supervisor. It watches three conditions: a reset-request comparator bit that must sit above its threshold, a flag saying the intermediate supply is in regulation, and an undervoltage-lockout flag. Reset is held low whenever any of them is bad. Once all of them are good, the block keeps reset low for one complete timeout period and only then lets it go high.

The request and regulation inputs pass through a sample-count glitch filter before they can affect the output. Lockout bypasses the filter and overrides every other input at once. The timeout length comes from a two-bit mode select. One code gives a short minimal period, one gives a fixed long period, and the other two take a cycle count from an input word. A fault pulse from the companion watchdog sends a released reset back through the same timeout. Each release produces a single-cycle pulse that tells the watchdog to start. All time is counted in cycles of a slow system clock.

Top module: `rto_reset_gen`

## Requirements
- R1: While `uvlo_i` is 1, or while the filtered request or filtered regulation level is 0, `rst_no` is 0 from the following clock edge onward.
- R2: A 0 on `req_ok_i` or `cp_good_i` must be seen for FILT_N consecutive clock edges before it counts. A shorter low pulse leaves `rst_no` at 1. A sustained low on an input that was good drives `rst_no` to 0 at the (FILT_N+1)th edge after the input falls. A return to 1 is filtered in the same way.
- R3: When all conditions turn good, the timeout starts on the edge after the filtered levels settle. `rst_no` rises exactly L edges after the timeout starts, which is FILT_N+1+L edges after the inputs became good. L is the selected timeout length.
- R4: `uvlo_i` acts unfiltered. Reset asserts on the first edge it is seen, and `rst_no` stays 0 while it is 1 whatever the other inputs do. After it clears with the qualifiers good, the timeout starts on the next edge, so release comes 1+L edges after clearing.
- R5: The `tmo_mode_i` encoding is: 2'b00 selects MIN_CYC cycles, 2'b01 selects INT_CYC cycles, and 2'b10 or 2'b11 selects `ext_tmo_i` cycles. The value is sampled when the timeout starts. An external value of 0 gives a one-cycle timeout.
- R6: If a qualifier goes bad during the timeout, the timeout is abandoned. After recovery the full period runs again from the start.
- R7: A `wdt_fault_i` pulse while reset is released and conditions are good drives `rst_no` to 0 on the next edge. Reset is released L edges after that. A fault during a running timeout restarts the period.
- R8: `release_o` is 1 for exactly the one cycle in which `rst_no` has just risen, and 0 at all other times.
- R9: During and directly after reset, `rst_no` and `release_o` are 0 and both filtered qualifiers read as bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow system clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_ok_i | input | 1 | Reset-request comparator, 1 = above threshold |
| cp_good_i | input | 1 | Intermediate supply in regulation |
| uvlo_i | input | 1 | Undervoltage lockout active |
| wdt_fault_i | input | 1 | Watchdog fault pulse |
| tmo_mode_i | input | 2 | Timeout source select |
| ext_tmo_i | input | CNT_W | Programmed timeout in clock cycles |
| rst_no | output | 1 | Active-low supervisory reset |
| release_o | output | 1 | One-cycle pulse when reset is released |

## Verification
A filter counter that is off by one moves the assert and release edges by one cycle. A timer that fails to reload, or that keeps a stale load value, shortens the release that follows an aborted or fault-restarted period. A sequencer stuck in the wrong state shows up either as a missing release or as a reset that ignores lockout. The bench therefore counts edges from each stimulus to the change on `rst_no` and compares the count with the exact figure given in the requirements. Each of these faults then shows at the ports within one timeout period of the stimulus that exposes it.

// File: rtl/rto_pkg.sv
package rto_pkg;
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_TIME = 2'd1,
        ST_RUN  = 2'd2
    } rto_state_e;

    localparam logic [1:0] MODE_MIN = 2'b00;
    localparam logic [1:0] MODE_INT = 2'b01;
endpackage

// File: rtl/rto_deglitch.sv
module rto_deglitch #(
    parameter int FILT_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic lvl_o
);
    localparam int CW = $clog2(FILT_N + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d = flt_q;
        if (raw_i == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(FILT_N - 1)) begin
            flt_d.lvl = raw_i;
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign lvl_o = flt_q.lvl;
endmodule

// File: rtl/rto_timer.sv
module rto_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = (load_val_i == '0) ? CNT_W'(1) : load_val_i;
        end else if (run_i && tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expire_o = (tmr_q.cnt == CNT_W'(1));
endmodule

// File: rtl/rto_reset_gen.sv
module rto_reset_gen
    import rto_pkg::*;
#(
    parameter int FILT_N  = 4,
    parameter int CNT_W   = 16,
    parameter int MIN_CYC = 24,
    parameter int INT_CYC = 6400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_ok_i,
    input  logic             cp_good_i,
    input  logic             uvlo_i,
    input  logic             wdt_fault_i,
    input  logic [1:0]       tmo_mode_i,
    input  logic [CNT_W-1:0] ext_tmo_i,
    output logic             rst_no,
    output logic             release_o
);
    localparam int NQUAL = 2;

    typedef struct packed {
        rto_state_e st;
        logic       rel;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NQUAL-1:0] qual_raw;
    logic [NQUAL-1:0] qual_flt;
    logic             all_good;
    logic             tmr_load;
    logic             tmr_run;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmo_len;

    assign qual_raw = {cp_good_i, req_ok_i};

    for (genvar g = 0; g < NQUAL; g++) begin : g_qual
        rto_deglitch #(.FILT_N(FILT_N)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (qual_raw[g]),
            .lvl_o (qual_flt[g])
        );
    end

    assign all_good = (&qual_flt) && !uvlo_i;

    always_comb begin
        case (tmo_mode_i)
            MODE_MIN: tmo_len = CNT_W'(MIN_CYC);
            MODE_INT: tmo_len = CNT_W'(INT_CYC);
            default:  tmo_len = ext_tmo_i;
        endcase
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.rel = 1'b0;
        tmr_load  = 1'b0;
        case (seq_q.st)
            ST_HOLD: begin
                if (all_good) begin
                    tmr_load = 1'b1;
                    seq_d.st = ST_TIME;
                end
            end
            ST_TIME: begin
                if (!all_good) begin
                    seq_d.st = ST_HOLD;
                end else if (wdt_fault_i) begin
                    tmr_load = 1'b1;
                end else if (tmr_expire) begin
                    seq_d.st  = ST_RUN;
                    seq_d.rel = 1'b1;
                end
            end
            ST_RUN: begin
                if (!all_good) begin
                    seq_d.st = ST_HOLD;
                end else if (wdt_fault_i) begin
                    tmr_load = 1'b1;
                    seq_d.st = ST_TIME;
                end
            end
            default: seq_d.st = ST_HOLD;
        endcase
    end

    assign tmr_run = (seq_q.st == ST_TIME);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_HOLD, rel: 1'b0};
        else        seq_q <= seq_d;
    end

    rto_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmo_len),
        .run_i      (tmr_run),
        .expire_o   (tmr_expire)
    );

    assign rst_no    = (seq_q.st == ST_RUN);
    assign release_o = seq_q.rel;
endmodule

// File: rtl/rto_reset_gen_chk.sv
module rto_reset_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic uvlo_i,
    input logic wdt_fault_i,
    input logic all_good,
    input logic rst_no,
    input logic release_o
);
    AST_BAD_QUAL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !all_good |=> !rst_no); // R1
    AST_UVLO_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_i |=> !rst_no); // R4
    AST_RISE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_no) |-> $past(all_good)); // R3
    AST_FAULT_REASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_fault_i && rst_no) |=> !rst_no); // R7
    AST_REL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o); // R8
    AST_REL_WITH_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_no) |-> release_o); // R8
    AST_REL_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |-> rst_no); // R8
endmodule

bind rto_reset_gen rto_reset_gen_chk i_chk (.*);

// File: tb/test_rto_reset_gen.sv
module test_rto_reset_gen;
    localparam int FN   = 4;
    localparam int CW   = 12;
    localparam int MINC = 5;
    localparam int INTC = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_ok = 1'b0;
    logic          cp_good = 1'b0;
    logic          uvlo = 1'b0;
    logic          wdt_fault = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] ext_tmo = '0;
    logic          rst_no;
    logic          release_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rto_reset_gen #(.FILT_N(FN), .CNT_W(CW), .MIN_CYC(MINC), .INT_CYC(INTC)) i_rto_reset_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_ok_i    (req_ok),
        .cp_good_i   (cp_good),
        .uvlo_i      (uvlo),
        .wdt_fault_i (wdt_fault),
        .tmo_mode_i  (mode),
        .ext_tmo_i   (ext_tmo),
        .rst_no      (rst_no),
        .release_o   (release_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic edges_to(input logic lvl, output int n);
        n = 0;
        while (rst_no !== lvl && n < 400) begin
            tick(1);
            n++;
        end
    endtask

    task automatic t_reset;
        chk("R9 rst_no in reset", rst_no, 0);
        chk("R9 release_o in reset", release_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        req_ok = 1'b1;
        tick(FN + 6);
        chk("R1 regulation bad keeps reset", rst_no, 0);
        req_ok = 1'b0;
        tick(FN + 2);
    endtask

    task automatic t_powerup;
        int n;
        mode = 2'b00;
        req_ok = 1'b1;
        cp_good = 1'b1;
        edges_to(1'b1, n);
        chk("R3 R5 minimal timeout release edge", n, FN + 1 + MINC);
        chk("R8 release pulse at rise", release_o, 1);
        tick(1);
        chk("R8 release pulse ends", release_o, 0);
        chk("R3 stays released", rst_no, 1);
    endtask

    task automatic t_glitch;
        int n;
        req_ok = 1'b0;
        tick(FN - 1);
        req_ok = 1'b1;
        tick(FN + 4);
        chk("R2 short request glitch ignored", rst_no, 1);
        cp_good = 1'b0;
        tick(FN - 1);
        cp_good = 1'b1;
        tick(FN + 4);
        chk("R2 short regulation glitch ignored", rst_no, 1);
        req_ok = 1'b0;
        edges_to(1'b0, n);
        chk("R2 R1 sustained low asserts", n, FN + 1);
        mode = 2'b01;
        req_ok = 1'b1;
        edges_to(1'b1, n);
        chk("R5 internal timeout release edge", n, FN + 1 + INTC);
    endtask

    task automatic t_abort;
        int n;
        cp_good = 1'b0;
        tick(FN + 1);
        chk("R1 regulation loss asserts", rst_no, 0);
        cp_good = 1'b1;
        tick(FN + 1 + 8);
        chk("R3 still asserted mid timeout", rst_no, 0);
        cp_good = 1'b0;
        tick(FN + 2);
        cp_good = 1'b1;
        edges_to(1'b1, n);
        chk("R6 full period after abort", n, FN + 1 + INTC);
    endtask

    task automatic t_uvlo;
        int n;
        uvlo = 1'b1;
        tick(1);
        chk("R4 lockout asserts on first edge", rst_no, 0);
        wdt_fault = 1'b1;
        tick(1);
        wdt_fault = 1'b0;
        tick(40);
        chk("R4 lockout holds with good inputs", rst_no, 0);
        uvlo = 1'b0;
        edges_to(1'b1, n);
        chk("R4 release after lockout clears", n, 1 + INTC);
    endtask

    task automatic t_wdt;
        int n;
        mode = 2'b10;
        ext_tmo = 12'd7;
        tick(2);
        wdt_fault = 1'b1;
        tick(1);
        wdt_fault = 1'b0;
        chk("R7 fault asserts next edge", rst_no, 0);
        edges_to(1'b1, n);
        chk("R7 R5 external timeout after fault", n, 7);
        chk("R8 release pulse after fault", release_o, 1);
        mode = 2'b11;
        ext_tmo = 12'd9;
        wdt_fault = 1'b1;
        tick(1);
        wdt_fault = 1'b0;
        tick(4);
        wdt_fault = 1'b1;
        tick(1);
        wdt_fault = 1'b0;
        edges_to(1'b1, n);
        chk("R7 fault in timeout restarts period", n, 9);
        ext_tmo = 12'd0;
        tick(2);
        wdt_fault = 1'b1;
        tick(1);
        wdt_fault = 1'b0;
        chk("R5 zero external asserts", rst_no, 0);
        edges_to(1'b1, n);
        chk("R5 zero external one cycle", n, 1);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_powerup();
        t_glitch();
        t_abort();
        t_uvlo();
        t_wdt();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
        end
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule